// File: doc/BRIEF.md
# Time-Base Watchdog Timer

This block keeps a free-running 64-bit time base and watches one bit of it that software selects. Each rising edge of that bit is a timeout. Timeouts drive a two-step status sequence. The first timeout arms the watchdog. The second timeout latches an interrupt flag, which raises a critical interrupt when that interrupt is enabled. A third timeout, arriving while both flags are still set, fires the reset action that software chose beforehand.

The reset action is chosen by a two-bit control field. Once software writes a non-zero value there, the field locks. It unlocks only when the action fires or when a hardware reset occurs. When the action fires, the chosen value is copied to the reset-status output and the field returns to zero. Software reads and writes a control word and a status word through a simple write port, and reads both words on dedicated outputs. The time base can be loaded directly, which lets a test reach any tap transition without counting up to it.

Top module: `wdt_timebase_unit`

## Requirements
- R1: After reset the time base is zero. It increments by one in each cycle that `tick_en` is high. A cycle with `tb_load` high replaces it with `tb_load_val`, and the load takes priority over the increment.
- R2: The tap select is control bits [5:0]: a 4-bit extension in [5:2] forms the upper part and a 2-bit period in [1:0] forms the lower part. Select value s taps time-base bit 63-s, so 0 taps the MSB and 63 taps the LSB.
- R3: A timeout is a 0-to-1 change of the tapped bit, seen in the cycle after the time base changes. A falling or steady tapped bit leaves the status unchanged.
- R4: Status bit 0 is the arm flag and status bit 1 is the interrupt flag. On a timeout, the arm flag is set if it is clear. Otherwise the interrupt flag is set if it is clear. Otherwise the reset action is taken.
- R5: `wd_irq` is high exactly when status bit 1 and the interrupt enable (control bit 8) are both set.
- R6: The reset-control field is control bits [7:6]. When the reset action fires with the field at 01 or 10, the field value is copied into status bits [3:2] and onto `rst_stat` in the next cycle, and the field returns to 00.
- R7: A firing with field value 01 gives a one-cycle `chkstop` pulse. A firing with field value 10 gives a one-cycle `rst_req` pulse. The two pulses are never high together.
- R8: With the field at 00 or at the reserved value 11, a third timeout produces no pulse and leaves the field and status bits [3:2] unchanged.
- R9: A control write updates bits [7:6] only while they read 00. Any other write to them is ignored, while the remaining control bits are still written.
- R10: Writing 1 to status bit 0 or bit 1 clears it; status bits [3:2] ignore writes. If a timeout sets a bit in the same cycle that a write clears it, the bit ends up set.
- R11: After reset, the control and status words are zero and `wd_irq`, `chkstop`, `rst_req` and `rst_stat` are low. Control bits [17:9] are stored as written and read back. Bits above 17 of both words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base increment enable |
| tb_load | input | 1 | Load the time base with `tb_load_val` |
| tb_load_val | input | 64 | Value loaded into the time base |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the status word |
| reg_wdata | input | 32 | Write data |
| tb_value | output | 64 | Current time base |
| ctrl_rd | output | 32 | Control word readback |
| stat_rd | output | 32 | Status word readback |
| wd_irq | output | 1 | Critical watchdog interrupt |
| rst_stat | output | 2 | Reset-control value of the last reset action |
| chkstop | output | 1 | One-cycle checkstop pulse |
| rst_req | output | 1 | One-cycle reset-request pulse |

## Verification
Every piece of state in this block reaches a port within one cycle. A wrong arm or interrupt flag shows on `stat_rd` in the cycle after the faulty timeout, and on `wd_irq` when interrupts are enabled. A wrong tap or a missed edge shows as a status word that stays put, or changes, one cycle after the time base crosses the tap. A lock that fails to hold appears on `ctrl_rd` right after the ignored write. A mis-decoded field shows either as a pulse on the wrong output or as `rst_stat` holding the wrong value from the cycle after the firing onward.

// File: rtl/wdt_pkg.sv
// Package: shared widths, field types and codes for the time-base watchdog.
// Assumes a 64-bit time base addressed by a 6-bit tap select.
package wdt_pkg;

    localparam int TB_W  = 64;
    localparam int SEL_W = $clog2(TB_W);
    localparam int REG_W = 32;

    // Register addresses on the write port
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Reset-control codes
    typedef enum logic [1:0] {
        RC_NONE    = 2'b00,
        RC_CHKSTOP = 2'b01,
        RC_RESET   = 2'b10,
        RC_RSVD    = 2'b11
    } rctl_e;

    // Control word, LSB field last: sel[5:0], rctl[7:6], wd_ie[8], ...
    typedef struct packed {
        logic            auto_rel;
        logic            fi_ie;
        logic [1:0]      fi_per;
        logic [3:0]      fi_ext;
        logic            dec_ie;
        logic            wd_ie;
        rctl_e           rctl;
        logic [SEL_W-1:0] wd_sel;
    } wdt_ctrl_t;

    // Status word: arm[0], int[1], rst_fld[3:2]
    typedef struct packed {
        logic [1:0] rst_fld;
        logic       int_st;
        logic       arm;
    } wdt_stat_t;

    localparam int CTRL_W = $bits(wdt_ctrl_t);
    localparam int STAT_W = $bits(wdt_stat_t);

endpackage

// File: rtl/wdt_timebase.sv
// Module: free-running time-base counter with a direct load.
// Assumes load has priority over the increment; synchronous active-low reset.
module wdt_timebase #(
    parameter int TB_W = wdt_pkg::TB_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            load_en,
    input  logic [TB_W-1:0] load_val,
    output logic [TB_W-1:0] tb_q
);

    // Count on each tick, or take the loaded value
    always_ff @(posedge clk) begin
        if (!rst_n)
            tb_q <= '0;
        else if (load_en)
            tb_q <= load_val;
        else if (tick_en)
            tb_q <= tb_q + 1'b1;
    end

    // R1: an unloaded tick adds exactly one
    p_tb_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick_en) && !$past(load_en) |-> tb_q == $past(tb_q) + 1'b1);

    // R1: a load lands as written
    p_tb_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load_en) |-> tb_q == $past(load_val));

endmodule

// File: rtl/wdt_tap_edge.sv
// Module: picks one time-base bit (select 0 = MSB) and flags its rising edge.
// Assumes the previous tap level resets to 0, matching a zero time base.
module wdt_tap_edge #(
    parameter int TB_W  = wdt_pkg::TB_W,
    localparam int SEL_W = $clog2(TB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TB_W-1:0]  tb,
    input  logic [SEL_W-1:0] sel,
    output logic             expiry
);

    logic [TB_W-1:0] tb_rev;
    logic            tap_now;
    logic            tap_q;

    // Bit-reverse the time base so select counts down from the MSB
    for (genvar i = 0; i < TB_W; i++) begin : g_rev
        assign tb_rev[i] = tb[TB_W-1-i];
    end

    // Current tapped level and rising-edge flag
    always_comb begin
        tap_now = tb_rev[sel];
        expiry  = tap_now & ~tap_q;
    end

    // Remember the tapped level for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            tap_q <= 1'b0;
        else
            tap_q <= tap_now;
    end

    // R3: the stored level trails the tap by one cycle
    p_tap_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tap_q == $past(tap_now));

endmodule

// File: rtl/wdt_regs.sv
// Module: control and status registers, the timeout stage sequence and the
// reset-action outputs. Assumes one write per cycle and a one-cycle expiry strobe.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = wdt_pkg::REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expiry,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output wdt_ctrl_t         ctrl_q,
    output wdt_stat_t         stat_q,
    output logic              wd_irq,
    output logic              chkstop,
    output logic              rst_req
);

    wdt_ctrl_t ctrl_d;
    wdt_ctrl_t wr_val;
    wdt_stat_t stat_d;
    logic      wr_ctrl;
    logic      wr_stat;
    logic      fire;
    logic      chk_q;
    logic      req_q;
    logic      unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:CTRL_W];

    // Decode writes and decide whether the reset action fires
    always_comb begin
        wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
        wr_stat = reg_we && (reg_addr == ADDR_STAT);
        wr_val  = wdt_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        fire    = expiry && stat_q.arm && stat_q.int_st &&
                  ((ctrl_q.rctl == RC_CHKSTOP) || (ctrl_q.rctl == RC_RESET));
    end

    // Next control word: write-once reset field, cleared by a firing
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d      = wr_val;
            ctrl_d.rctl = (ctrl_q.rctl == RC_NONE) ? wr_val.rctl : ctrl_q.rctl;
        end
        if (fire)
            ctrl_d.rctl = RC_NONE;
    end

    // Next status word: write-one-to-clear, then timeout stepping wins
    always_comb begin
        stat_d = stat_q;
        if (wr_stat) begin
            stat_d.arm    = stat_q.arm    & ~reg_wdata[0];
            stat_d.int_st = stat_q.int_st & ~reg_wdata[1];
        end
        if (expiry) begin
            if (!stat_q.arm)
                stat_d.arm = 1'b1;
            else if (!stat_q.int_st)
                stat_d.int_st = 1'b1;
        end
        if (fire)
            stat_d.rst_fld = ctrl_q.rctl;
    end

    // Register state and the one-cycle action pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
            chk_q  <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
            chk_q  <= fire && (ctrl_q.rctl == RC_CHKSTOP);
            req_q  <= fire && (ctrl_q.rctl == RC_RESET);
        end
    end

    // Drive the interrupt and pulse outputs
    always_comb begin
        wd_irq  = stat_q.int_st & ctrl_q.wd_ie;
        chkstop = chk_q;
        rst_req = req_q;
    end

    // R4: a timeout on a disarmed watchdog arms it
    p_arm_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(expiry) && !$past(stat_q.arm) |-> stat_q.arm);

    // R4: a timeout on an armed watchdog latches the interrupt flag
    p_int_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(expiry) && $past(stat_q.arm) && !$past(stat_q.int_st)
        |-> stat_q.int_st);

    // R6: a firing records the field and frees it
    p_fire_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(fire)
        |-> ctrl_q.rctl == RC_NONE && stat_q.rst_fld == $past(ctrl_q.rctl));

    // R7: pulses are exclusive
    p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chk_q, req_q}));

    // R7: each pulse lasts a single cycle
    p_chk_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q |=> !chk_q);
    p_req_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

    // R8: an idle or reserved field never pulses
    p_rsvd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.rctl == RC_NONE || ctrl_q.rctl == RC_RSVD) |=> !chk_q && !req_q);

    // R9: a locked field only changes through a firing
    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(ctrl_q.rctl) != RC_NONE) && !$past(fire)
        |-> ctrl_q.rctl == $past(ctrl_q.rctl));

    // R10: a clear of the arm flag without a timeout takes effect
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_stat) && $past(reg_wdata[0]) && !$past(expiry)
        |-> !stat_q.arm);

endmodule

// File: rtl/wdt_timebase_unit.sv
// Module: top of the time-base watchdog. Joins the counter, the tap edge
// detector and the register block, and widens register readback to the bus.
// Assumes a single clock domain and a synchronous active-low reset.
module wdt_timebase_unit
    import wdt_pkg::*;
#(
    parameter int TB_BITS  = wdt_pkg::TB_W,
    parameter int BUS_W    = wdt_pkg::REG_W,
    localparam int SELW    = $clog2(TB_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               tb_load,
    input  logic [TB_BITS-1:0] tb_load_val,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [BUS_W-1:0]   reg_wdata,
    output logic [TB_BITS-1:0] tb_value,
    output logic [BUS_W-1:0]   ctrl_rd,
    output logic [BUS_W-1:0]   stat_rd,
    output logic               wd_irq,
    output logic [1:0]         rst_stat,
    output logic               chkstop,
    output logic               rst_req
);

    logic      expiry;
    wdt_ctrl_t ctrl_q;
    wdt_stat_t stat_q;

    wdt_timebase #(.TB_W(TB_BITS)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load_en  (tb_load),
        .load_val (tb_load_val),
        .tb_q     (tb_value)
    );

    wdt_tap_edge #(.TB_W(TB_BITS)) u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .tb     (tb_value),
        .sel    (ctrl_q.wd_sel[SELW-1:0]),
        .expiry (expiry)
    );

    wdt_regs #(.DATA_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .expiry    (expiry),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ctrl_q    (ctrl_q),
        .stat_q    (stat_q),
        .wd_irq    (wd_irq),
        .chkstop   (chkstop),
        .rst_req   (rst_req)
    );

    // Zero-extend the register words onto the readback buses
    always_comb begin
        ctrl_rd  = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
        stat_rd  = {{(BUS_W-STAT_W){1'b0}}, stat_q};
        rst_stat = stat_q.rst_fld;
    end

endmodule

// File: tb/tb_wdt_timebase_unit.sv
module tb_wdt_timebase_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        tb_load = 1'b0;
    logic [63:0] tb_load_val = '0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [63:0] tb_value;
    logic [31:0] ctrl_rd, stat_rd;
    logic        wd_irq, chkstop, rst_req;
    logic [1:0]  rst_stat;

    int n_vec = 0;
    int n_bad = 0;
    int n_chk_pulses = 0;
    int n_req_pulses = 0;

    // Behavioural reference state
    logic [63:0] m_tb = '0;
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_stat = '0;
    bit          m_prev = 0;
    bit          m_chk = 0;
    bit          m_req = 0;

    always #5 clk = ~clk;

    wdt_timebase_unit dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tb_load(tb_load),
        .tb_load_val(tb_load_val), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tb_value(tb_value), .ctrl_rd(ctrl_rd),
        .stat_rd(stat_rd), .wd_irq(wd_irq), .rst_stat(rst_stat),
        .chkstop(chkstop), .rst_req(rst_req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: advances on each rising edge from the requirement text
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tb = '0; m_ctrl = '0; m_stat = '0; m_prev = 0; m_chk = 0; m_req = 0;
        end else begin
            int          s;
            bit          tap, exp_ev, fire;
            logic [1:0]  rc;
            logic [31:0] nc, ns;
            s      = int'(m_ctrl[5:0]);
            tap    = m_tb[63 - s];
            exp_ev = tap && !m_prev;
            rc     = m_ctrl[7:6];
            fire   = exp_ev && m_stat[0] && m_stat[1] && (rc == 2'b01 || rc == 2'b10);
            nc = m_ctrl;
            if (reg_we && reg_addr == 1'b0) begin
                nc = {14'd0, reg_wdata[17:0]};
                if (rc != 2'b00) nc[7:6] = rc;
            end
            if (fire) nc[7:6] = 2'b00;
            ns = m_stat;
            if (reg_we && reg_addr == 1'b1) ns[1:0] = m_stat[1:0] & ~reg_wdata[1:0];
            if (exp_ev) begin
                if (!m_stat[0]) ns[0] = 1'b1;
                else if (!m_stat[1]) ns[1] = 1'b1;
            end
            if (fire) ns[3:2] = rc;
            m_chk  = fire && rc == 2'b01;
            m_req  = fire && rc == 2'b10;
            m_prev = tap;
            m_ctrl = nc;
            m_stat = ns;
            if (tb_load) m_tb = tb_load_val;
            else if (tick_en) m_tb = m_tb + 64'd1;
        end
    end

    // Compare every output against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 time base", tb_value, m_tb);
            check("R11 control word", {32'd0, ctrl_rd}, {32'd0, m_ctrl});
            check("R4 status word", {32'd0, stat_rd}, {32'd0, m_stat});
            check("R5 interrupt", {63'd0, wd_irq}, {63'd0, m_stat[1] & m_ctrl[8]});
            check("R6 reset status", {62'd0, rst_stat}, {62'd0, m_stat[3:2]});
            check("R7 checkstop", {63'd0, chkstop}, {63'd0, m_chk});
            check("R7 reset request", {63'd0, rst_req}, {63'd0, m_req});
            if (chkstop) n_chk_pulses++;
            if (rst_req) n_req_pulses++;
        end
    end

    task automatic wr(input logic a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ld(input logic [63:0] v);
        tb_load = 1'b1; tb_load_val = v;
        @(negedge clk);
        tb_load = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int base_chk, base_req;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11 ctrl after reset", {32'd0, ctrl_rd}, 64'd0);
        check("R11 status after reset", {32'd0, stat_rd}, 64'd0);
        check("R11 outputs after reset", {60'd0, wd_irq, chkstop, rst_req, |rst_stat}, 64'd0);
        check("R1 time base after reset", tb_value, 64'd0);

        // R2: select 0 taps the MSB
        wr(1'b0, 32'h0000_0100);
        ld(64'h7FFF_FFFF_FFFF_FFFF);
        ticks(1);
        @(negedge clk);
        check("R2 msb tap arms", {63'd0, stat_rd[0]}, 64'd1);

        // R2/R5: select 20 taps bit 43; second timeout raises the interrupt
        wr(1'b0, 32'h0000_0114);
        ld((64'd1 << 43) - 64'd1);
        ticks(1);
        @(negedge clk);
        check("R4 second timeout", {62'd0, stat_rd[1:0]}, 64'd3);
        check("R5 interrupt raised", {63'd0, wd_irq}, 64'd1);

        // R3: a falling and a steady tap leave status alone
        wr(1'b1, 32'h3);
        ld(64'd0);
        ld(64'd0);
        repeat (2) @(negedge clk);
        check("R3 falling tap ignored", {32'd0, stat_rd}, 64'd0);

        // R10: clear racing a timeout keeps the bit
        wr(1'b0, 32'h0000_013F);
        ld(64'd1);
        wr(1'b1, 32'h3);
        check("R10 race keeps arm", {62'd0, stat_rd[1:0]}, 64'd1);
        wr(1'b1, 32'h1);
        check("R10 clear works", {62'd0, stat_rd[1:0]}, 64'd0);

        // R9: lock the field at 10, attempt to change it
        wr(1'b0, 32'h0000_01BF);
        wr(1'b0, 32'h0002_017F);
        check("R9 locked field", {62'd0, ctrl_rd[7:6]}, 64'd2);
        check("R11 other fields written", {63'd0, ctrl_rd[17]}, 64'd1);

        // R6/R7: three timeouts on the LSB tap fire a reset request
        base_chk = n_chk_pulses; base_req = n_req_pulses;
        ld(64'd0);
        @(negedge clk);
        ticks(8);
        @(negedge clk);
        check("R7 one reset request", 64'(n_req_pulses - base_req), 64'd1);
        check("R7 no checkstop", 64'(n_chk_pulses - base_chk), 64'd0);
        check("R6 reset status 10", {62'd0, rst_stat}, 64'd2);
        check("R6 field freed", {62'd0, ctrl_rd[7:6]}, 64'd0);

        // R7: field 01 gives a checkstop, status reports 01
        wr(1'b0, 32'h0000_017F);
        ticks(3);
        @(negedge clk);
        check("R7 one checkstop", 64'(n_chk_pulses - base_chk), 64'd1);
        check("R6 reset status 01", {62'd0, rst_stat}, 64'd1);

        // R8: reserved field produces nothing
        wr(1'b0, 32'h0000_01FF);
        base_chk = n_chk_pulses; base_req = n_req_pulses;
        ticks(6);
        @(negedge clk);
        check("R8 reserved no pulses", 64'((n_chk_pulses - base_chk) + (n_req_pulses - base_req)), 64'd0);
        check("R8 reserved field kept", {62'd0, ctrl_rd[7:6]}, 64'd3);
        check("R8 reset status kept", {62'd0, rst_stat}, 64'd1);

        // Random traffic against the model
        hw_reset();
        for (int i = 0; i < 4000; i++) begin
            if (i % 900 == 899) hw_reset();
            tick_en = ($urandom_range(0, 1) == 1);
            tb_load = ($urandom_range(0, 29) == 0);
            tb_load_val = {$urandom(), $urandom()};
            if ($urandom_range(0, 1) == 1)
                tb_load_val[$urandom_range(0, 63) -: 1] = 1'b0;
            reg_we = ($urandom_range(0, 11) == 0);
            reg_addr = ($urandom_range(0, 2) == 0) ? 1'b0 : 1'b1;
            reg_wdata = $urandom();
            if (reg_addr == 1'b0)
                reg_wdata[5:0] = 6'(58 + $urandom_range(0, 5));
            @(negedge clk);
        end
        tick_en = 1'b0; tb_load = 1'b0; reg_we = 1'b0;

        // R11: a hardware reset restores the idle state
        hw_reset();
        check("R11 ctrl after second reset", {32'd0, ctrl_rd}, 64'd0);
        check("R11 status after second reset", {32'd0, stat_rd}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule